// File: doc/BRIEF.md
# Two-Stage I2C Bit-Rate Generator

This block derives the SCL timing of an I2C master from a fast source clock. A fixed prescaler produces a slow tick. Two nested counters then divide that tick into SCL half-periods. The inner counter counts samples and the outer counter counts steps. Each half-period therefore lasts sample_count × step_count ticks, and the bus frequency is f_clk / (PRESC_DIV × 2 × sample_count × step_count).

Two packed configuration words hold the counts, each stored as the count minus one. The normal word covers standard and fast mode. The high-speed word covers high-speed mode and carries its own enable code. The `hs_sel` input picks the high-speed set once a master-code phase has finished, but only if the enable code is present. A new selection or a new field value is loaded only at a half-period boundary, or while the generator is stopped.

The block has three outputs: the SCL level, a strobe where SDA may be driven, and a strobe where SDA should be sampled. The line drivers and the byte-level protocol sit outside this block.

Top module: `i2c_brg`

## Requirements
- R1: While reset is asserted, or while `run` is low, `scl_o` is 1 and `drive_stb` is 0. No counting takes place, and the first half-period after `run` rises is a high half.
- R2: A prescaler tick occurs every PRESC_DIV clocks (default 5). An SCL half-period lasts exactly PRESC_DIV × sample_count × step_count clocks.
- R3: In normal mode, sample_count − 1 is read from `nrm_timing[10:8]` (counts 1 to 8) and step_count − 1 from `nrm_timing[5:0]` (counts 1 to 64).
- R4: When `hs_sel` is 1 and `hs_timing[1:0]` equals 3, sample_count − 1 is read from `hs_timing[14:12]` and step_count − 1 from `hs_timing[10:8]`. Both counts then range from 1 to 8.
- R5: When `hs_timing[1:0]` is not 3 (for example when the word is written as 0), the normal fields are used even if `hs_sel` is 1.
- R6: A change of `hs_sel` or of either configuration word during a running half-period leaves that half-period's length unchanged. The new values govern the following half-period.
- R7: `drive_stb` is a one-clock pulse. It is high exactly in the first clock of each low half of SCL.
- R8: `sample_stb` pulses exactly once per high half, in the clock of the prescaler tick at which floor((L−1)/2) ticks of the half have already elapsed, where L = sample_count × step_count. It never pulses while SCL is low.
- R9: While `run` stays high, SCL changes only in the clock after the last tick of a half-period. Its high and low halves have equal length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables bit-rate generation; low forces the idle state |
| hs_sel | input | 1 | Requests the high-speed field set |
| nrm_timing | input | CFG_W | Normal-mode count fields |
| hs_timing | input | CFG_W | High-speed count fields and enable code |
| scl_o | output | 1 | SCL level |
| drive_stb | output | 1 | Strobe marking where SDA may change |
| sample_stb | output | 1 | Strobe marking where SDA is sampled |

## Verification
The assertions check the local relations on every cycle. SCL sits high when idle, and it moves only after a half-period end. The drive strobe coincides exactly with a falling SCL. The sample strobe lands on a prescaler tick during a high half. The loaded count fields stay frozen between boundaries. The period arithmetic cannot be seen by any single-cycle property. That covers the product of the counts, the field positions in both words, the effect of the high-speed enable code, the deferral of a mid-half change and the sample position. Only the bench shows these, through its tick-level reference model and its measured half-period lengths.

// File: rtl/i2c_brg_pkg.sv
package i2c_brg_pkg;
   // Count-field widths
   localparam int SMP_W  = 3;
   localparam int NSTP_W = 6;
   localparam int HSTP_W = 3;

   // Field positions inside the configuration words
   localparam int NRM_SMP_LSB = 8;
   localparam int NRM_STP_LSB = 0;
   localparam int HS_SMP_LSB  = 12;
   localparam int HS_STP_LSB  = 8;
   localparam int HS_EN_LSB   = 0;
   localparam int HS_EN_W     = 2;
   localparam logic [HS_EN_W-1:0] HS_EN_CODE = 2'b11;

   typedef struct packed {
      logic [SMP_W-1:0]  smp_m1;
      logic [NSTP_W-1:0] stp_m1;
   } brg_cnt_t;
endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
   parameter int DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int PCW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_bypass
         wire unused_pre = clk ^ rst_n;
         assign tick = run;
      end else begin : g_count
         logic [PCW-1:0] pc_q;
         assign tick = run && (pc_q == PCW'(DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !run || tick) pc_q <= '0;
            else                        pc_q <= pc_q + PCW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/brg_field_sel.sv
module brg_field_sel
   import i2c_brg_pkg::*;
#(
   parameter int CFG_W = 16
) (
   input  logic             hs_sel,
   input  logic [CFG_W-1:0] nrm_timing,
   input  logic [CFG_W-1:0] hs_timing,
   output brg_cnt_t         nxt_cfg
);
   logic use_hs;
   wire  unused_cfg = ^{nrm_timing, hs_timing};

   assign use_hs = hs_sel && (hs_timing[HS_EN_LSB +: HS_EN_W] == HS_EN_CODE);

   always_comb begin
      if (use_hs) begin
         nxt_cfg.smp_m1 = hs_timing[HS_SMP_LSB +: SMP_W];
         nxt_cfg.stp_m1 = NSTP_W'(hs_timing[HS_STP_LSB +: HSTP_W]);
      end else begin
         nxt_cfg.smp_m1 = nrm_timing[NRM_SMP_LSB +: SMP_W];
         nxt_cfg.stp_m1 = nrm_timing[NRM_STP_LSB +: NSTP_W];
      end
   end
endmodule

// File: rtl/brg_half_timer.sv
module brg_half_timer
   import i2c_brg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     tick,
   input  brg_cnt_t nxt_cfg,
   output logic     scl_o,
   output logic     drive_stb,
   output logic     sample_stb,
   output logic     half_end,
   output brg_cnt_t cur_cfg
);
   localparam int PW = SMP_W + NSTP_W + 2;

   brg_cnt_t          cfg_q;
   logic [SMP_W-1:0]  s_q;
   logic [NSTP_W-1:0] t_q;
   logic              scl_q, drv_q;
   logic [PW-1:0]     smp_n, stp_n, half_len, elapsed, mid;
   logic              smp_last, stp_last;

   assign smp_last = (s_q == cfg_q.smp_m1);
   assign stp_last = (t_q == cfg_q.stp_m1);
   assign half_end = tick && smp_last && stp_last;

   // Position inside the half, in ticks, for the sample mark
   assign smp_n    = PW'(cfg_q.smp_m1) + PW'(1);
   assign stp_n    = PW'(cfg_q.stp_m1) + PW'(1);
   assign half_len = smp_n * stp_n;
   assign elapsed  = PW'(t_q) * smp_n + PW'(s_q);
   assign mid      = (half_len - PW'(1)) >> 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         s_q   <= '0;
         t_q   <= '0;
         scl_q <= 1'b1;
         drv_q <= 1'b0;
      end else if (!run) begin
         cfg_q <= nxt_cfg;
         s_q   <= '0;
         t_q   <= '0;
         scl_q <= 1'b1;
         drv_q <= 1'b0;
      end else begin
         drv_q <= 1'b0;
         if (tick) begin
            if (smp_last) begin
               s_q <= '0;
               if (stp_last) begin
                  t_q   <= '0;
                  scl_q <= ~scl_q;
                  drv_q <= scl_q;
                  cfg_q <= nxt_cfg;
               end else begin
                  t_q <= t_q + NSTP_W'(1);
               end
            end else begin
               s_q <= s_q + SMP_W'(1);
            end
         end
      end
   end

   assign scl_o      = scl_q;
   assign drive_stb  = drv_q;
   assign sample_stb = tick && scl_q && (elapsed == mid);
   assign cur_cfg    = cfg_q;
endmodule

// File: rtl/i2c_brg.sv
module i2c_brg
   import i2c_brg_pkg::*;
#(
   parameter int PRESC_DIV = 5,
   parameter int CFG_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hs_sel,
   input  logic [CFG_W-1:0] nrm_timing,
   input  logic [CFG_W-1:0] hs_timing,
   output logic             scl_o,
   output logic             drive_stb,
   output logic             sample_stb
);
   // Elaboration-time parameter checks
   if (PRESC_DIV < 1) begin : g_bad_div
      $error("i2c_brg: PRESC_DIV must be at least 1");
   end
   if (NRM_SMP_LSB + SMP_W > CFG_W || NRM_STP_LSB + NSTP_W > CFG_W) begin : g_bad_nrm
      $error("i2c_brg: normal fields exceed CFG_W");
   end
   if (HS_SMP_LSB + SMP_W > CFG_W || HS_STP_LSB + HSTP_W > CFG_W) begin : g_bad_hs
      $error("i2c_brg: high-speed fields exceed CFG_W");
   end
   if (HSTP_W > NSTP_W) begin : g_bad_stp
      $error("i2c_brg: high-speed step field wider than normal");
   end

   logic              tick, half_end;
   brg_cnt_t          nxt_cfg, cur_cfg;
   logic [SMP_W-1:0]  cur_smp;
   logic [NSTP_W-1:0] cur_stp;

   brg_prescaler #(.DIV(PRESC_DIV)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   brg_field_sel #(.CFG_W(CFG_W)) u_sel (
      .hs_sel    (hs_sel),
      .nrm_timing(nrm_timing),
      .hs_timing (hs_timing),
      .nxt_cfg   (nxt_cfg)
   );

   brg_half_timer u_half (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .nxt_cfg   (nxt_cfg),
      .scl_o     (scl_o),
      .drive_stb (drive_stb),
      .sample_stb(sample_stb),
      .half_end  (half_end),
      .cur_cfg   (cur_cfg)
   );

   assign cur_smp = cur_cfg.smp_m1;
   assign cur_stp = cur_cfg.stp_m1;
endmodule

// File: rtl/i2c_brg_chk.sv
module i2c_brg_chk
   import i2c_brg_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              scl_o,
   input logic              drive_stb,
   input logic              sample_stb,
   input logic              tick,
   input logic              half_end,
   input logic [SMP_W-1:0]  cur_smp,
   input logic [NSTP_W-1:0] cur_stp
);
   AST_IDLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (scl_o && !drive_stb)); // R1

   AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      drive_stb |-> $fell(scl_o)); // R7

   AST_FALL_HAS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_o) |-> drive_stb); // R7

   AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (scl_o && tick)); // R8

   AST_SCL_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$stable(scl_o)) |-> $past(half_end)); // R9

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && !$past(half_end)) |-> $stable({cur_smp, cur_stp})); // R6
endmodule

bind i2c_brg i2c_brg_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .scl_o     (scl_o),
   .drive_stb (drive_stb),
   .sample_stb(sample_stb),
   .tick      (tick),
   .half_end  (half_end),
   .cur_smp   (cur_smp),
   .cur_stp   (cur_stp)
);

// File: tb/tb_i2c_brg.sv
`timescale 1ns/1ps
module tb_i2c_brg;
   localparam int DIV = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        hs_sel = 1'b0;
   logic [15:0] nrm_timing = 16'h0102;
   logic [15:0] hs_timing = 16'h0000;
   logic        scl_o, drive_stb, sample_stb;

   i2c_brg #(.PRESC_DIV(DIV), .CFG_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .run(run), .hs_sel(hs_sel),
      .nrm_timing(nrm_timing), .hs_timing(hs_timing),
      .scl_o(scl_o), .drive_stb(drive_stb), .sample_stb(sample_stb)
   );

   always #2.5 clk = ~clk;

   int total = 0, bad = 0, cyc = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Reference model: tick-level behaviour from the requirements
   function automatic int cfg_len(input bit sel, input logic [15:0] n, input logic [15:0] h);
      if (sel && h[1:0] == 2'b11)
         return (int'(h[14:12]) + 1) * (int'(h[10:8]) + 1);
      return (int'(n[10:8]) + 1) * (int'(n[5:0]) + 1);
   endfunction

   int m_pc, m_e, m_len, m_mid;
   bit m_scl, m_drv;

   always @(posedge clk) begin
      if (!rst_n || !run) begin
         m_pc = 0; m_e = 0; m_scl = 1'b1; m_drv = 1'b0;
         m_len = rst_n ? cfg_len(hs_sel, nrm_timing, hs_timing) : 1;
         m_mid = (m_len - 1) / 2;
      end else begin
         m_drv = 1'b0;
         if (m_pc == DIV - 1) begin
            m_pc = 0;
            if (m_e == m_len - 1) begin
               m_e = 0;
               m_drv = m_scl;
               m_scl = !m_scl;
               m_len = cfg_len(hs_sel, nrm_timing, hs_timing);
               m_mid = (m_len - 1) / 2;
            end else m_e++;
         end else m_pc++;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         bit exp_s;
         exp_s = run && rst_n && (m_pc == DIV - 1) && m_scl && (m_e == m_mid);
         chk(scl_o === m_scl, "R9 scl level", int'(scl_o), int'(m_scl));
         chk(drive_stb === m_drv, "R7 drive strobe", int'(drive_stb), int'(m_drv));
         chk(sample_stb === exp_s, "R8 sample strobe", int'(sample_stb), int'(exp_s));
      end
   end

   task automatic at_edge();
      @(posedge clk); #1;
   endtask

   task automatic wait_edge();
      logic prev;
      @(negedge clk);
      prev = scl_o;
      do @(negedge clk); while (scl_o === prev);
   endtask

   task automatic meas(output int len);
      int t0;
      wait_edge();
      t0 = cyc;
      wait_edge();
      len = cyc - t0;
   endtask

   task automatic settle_and_check(input int exp, input string req);
      int len;
      wait_edge();
      meas(len);
      chk(len == exp, req, len, exp);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      int len, t0, offs, ns, nd;
      repeat (3) @(negedge clk);
      chk(scl_o === 1'b1 && drive_stb === 1'b0 && sample_stb === 1'b0, "R1 reset state",
          int'({scl_o, drive_stb, sample_stb}), 4);
      at_edge(); rst_n = 1'b1;
      repeat (3) at_edge();
      run = 1'b1;

      // R2 R3: S=2, T=3 -> 30 clocks per half, both halves equal (R9)
      meas(len); chk(len == 30, "R2 R3 half length S2 T3", len, 30);
      meas(len); chk(len == 30, "R9 equal halves", len, 30);

      at_edge(); nrm_timing = 16'h0000;      // S=1, T=1
      settle_and_check(5, "R2 minimum half length");
      at_edge(); nrm_timing = 16'h0705;      // S=8, T=6
      settle_and_check(240, "R3 field decode S8 T6");
      at_edge(); nrm_timing = 16'h003F;      // S=1, T=64
      settle_and_check(320, "R3 maximum step count");

      // R4: high-speed set S=4, T=2
      at_edge(); nrm_timing = 16'h0102; hs_sel = 1'b1; hs_timing = 16'h3103;
      settle_and_check(40, "R4 high-speed fields");
      at_edge(); hs_timing = 16'h7703;        // S=8, T=8
      settle_and_check(320, "R4 high-speed maximum");

      // R5: enable code absent -> normal set
      at_edge(); hs_timing = 16'h3100;
      settle_and_check(30, "R5 enable code missing");
      at_edge(); hs_timing = 16'h0000;
      settle_and_check(30, "R5 high-speed word zero");

      // R6: change mid-half, current half keeps its length
      at_edge(); hs_sel = 1'b0;
      wait_edge();
      t0 = cyc;
      repeat (7) at_edge();
      nrm_timing = 16'h0001;                  // S=1, T=2
      wait_edge();
      chk(cyc - t0 == 30, "R6 running half unchanged", cyc - t0, 30);
      t0 = cyc;
      wait_edge();
      chk(cyc - t0 == 10, "R6 next half uses new fields", cyc - t0, 10);

      // R7 R8: strobe placement over one full period with S=2, T=3
      at_edge(); nrm_timing = 16'h0102;
      wait_edge(); wait_edge();
      do @(negedge clk); while (scl_o !== 1'b0);
      chk(drive_stb === 1'b1, "R7 drive at first low clock", int'(drive_stb), 1);
      do @(negedge clk); while (scl_o !== 1'b1);
      offs = 0;
      while (sample_stb !== 1'b1 && offs < 40) begin @(negedge clk); offs++; end
      chk(offs == 14, "R8 sample position in high half", offs, 14);
      ns = 0; nd = 0;
      do @(negedge clk); while (scl_o !== 1'b1);
      for (int i = 0; i < 60; i++) begin
         if (sample_stb === 1'b1) ns++;
         if (drive_stb === 1'b1) nd++;
         @(negedge clk);
      end
      chk(ns == 1, "R8 one sample per period", ns, 1);
      chk(nd == 1, "R7 one drive per period", nd, 1);

      // R1: stop holds SCL high with no strobes
      at_edge(); run = 1'b0;
      nd = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (scl_o !== 1'b1 || drive_stb !== 1'b0 || sample_stb !== 1'b0) nd++;
      end
      chk(nd == 0, "R1 idle while stopped", nd, 0);

      // R1: restart begins with a full high half (S=2, T=3)
      at_edge(); run = 1'b1;
      t0 = cyc;
      do @(negedge clk); while (scl_o !== 1'b0);
      chk(cyc - t0 == 30, "R1 first half after start is high", cyc - t0, 30);

      repeat (10) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R2 run did not complete actual=%0d expected=%0d", cyc, 0);
         finish_run();
      end
   end
endmodule